// File: doc/BRIEF.md
# Interrupt Event Arbiter

This block sits beside an instruction sequencer and decides whether an interrupt-like event is taken, which one, and on which cycle. It receives three asynchronous pins: a non-maskable request, a maskable request and a reset request. It also receives the trap (single-step) flag, the interrupt-enable flag, a one-cycle strobe marking the start of each instruction, and three hold conditions from the sequencer. These holds are an explicit interrupt-delay step, an instruction that wrote a segment register, and a pending instruction prefix.

When an event is accepted, the block raises `takePulse` for one cycle. The sequencer uses that pulse to block normal decode and queue loading. Alongside the pulse the block presents an encoded entry select and, for the two events with a hard-wired vector, that vector number. For a maskable request the vector comes from the requesting device, so the block does not fetch or supply it. The block does not run the bus cycles or the handler.

Each pin passes through a two-stage synchroniser. The first stage captures on the falling clock edge and the second on the rising edge. The arbitration decision is registered, so the outputs appear on the cycle after the one in which the decision was made.

Top module: `intarb_top`

## Requirements
- R1: While `rstN` is low, and on the first cycle after it rises, `takePulse`, `entrySel`, `vecFixed` and `vecNum` are all 0.
- R2: A pin level driven during cycle k is seen by the arbitration in cycle k+1. The resulting take shows on the outputs in cycle k+2.
- R3: A rising edge on the synchronised non-maskable pin is remembered even if the pin falls again. It is taken at the next accepted boundary with `entrySel` = 1, `vecFixed` = 1 and `vecNum` = 2.
- R4: The non-maskable memory clears when its take is issued. A pin held high afterwards produces no further take until it falls and rises again.
- R5: A maskable request is taken only if the synchronised pin is high in the very cycle of an accepted boundary and `intEnable` is 1. It is then reported with `entrySel` = 2, `vecFixed` = 0 and `vecNum` = 0. A request that is high only between boundaries is not remembered.
- R6: A boundary seen with `trapFlag` = 1 arms a trap, which is taken at a later accepted boundary with `entrySel` = 0, `vecFixed` = 1 and `vecNum` = 1. An armed trap is discarded when a non-maskable or maskable take is issued at that boundary.
- R7: A boundary is accepted only when `delayHold`, `segWrite` and `prefixActive` are all 0. A held boundary takes nothing, but keeps a remembered non-maskable request and keeps or arms a trap.
- R8: Priority is reset, then non-maskable, then maskable, then trap. At most one take is issued per cycle.
- R9: A rising edge of the synchronised reset pin issues a take with `entrySel` = 3, `vecFixed` = 0 and `vecNum` = 0 on any cycle, boundary or not. While that pin stays high, no other take is issued, and the remembered non-maskable request and any armed trap are cleared.
- R10: Whenever `takePulse` is 0, `entrySel`, `vecFixed` and `vecNum` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset of the block's own flops |
| nmiPin | input | 1 | Asynchronous non-maskable request |
| intrPin | input | 1 | Asynchronous maskable request (level) |
| resetPin | input | 1 | Asynchronous processor reset request |
| trapFlag | input | 1 | Single-step flag |
| intEnable | input | 1 | Maskable-request enable flag |
| instrBoundary | input | 1 | One-cycle strobe at the first cycle of an instruction |
| delayHold | input | 1 | Interrupt-delay step active |
| segWrite | input | 1 | Current instruction wrote a segment register |
| prefixActive | input | 1 | Current instruction is a prefix |
| takePulse | output | 1 | One-cycle event take |
| entrySel | output | 2 | 0 trap, 1 non-maskable, 2 maskable, 3 reset |
| vecFixed | output | 1 | `vecNum` carries a hard-wired vector |
| vecNum | output | 8 | Hard-wired vector number, else 0 |

## Verification
The bench targets a short non-maskable pulse that falls before any boundary arrives. A design that samples the level instead of latching the edge would lose that event. It also targets a pin held high across several boundaries, where a design that failed to clear its memory would take repeatedly. Each of the three hold inputs is applied alone to a boundary while a non-maskable request and a trap are outstanding. A mistake there would show either as a take leaking through the hold or as a request dropped by it. The remaining cases are simultaneous requests from all sources, a maskable pulse that misses the boundary cycle, and a reset asserted off-boundary while other requests are outstanding. Wrong priority, a remembered maskable request, or a reset that waits for a boundary all appear as a mismatched `entrySel` or a misplaced pulse against the cycle model.

// File: rtl/intarb_pkg.sv
package intarb_pkg;

  typedef enum logic [1:0] {
    ENT_TRAP  = 2'd0,
    ENT_NMI   = 2'd1,
    ENT_MASK  = 2'd2,
    ENT_RESET = 2'd3
  } entry_e;

  // Request view produced by the datapath for the control
  typedef struct packed {
    logic resetReq;    // synchronised reset rising edge
    logic resetLevel;  // synchronised reset level
    logic nmiReq;      // remembered or fresh non-maskable request
    logic maskReq;     // maskable level qualified by enable
    logic trapReq;     // armed trap
  } req_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic takeReset;
    logic takeNmi;
    logic takeMask;
    logic takeTrap;
    logic boundaryOk;  // boundary with no hold active
    logic boundary;    // raw boundary strobe
    logic resetHold;   // reset pin held high
  } ctrl_strobes_t;

endpackage

// File: rtl/intarb_sync.sv
module intarb_sync #(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] firstQ;
  logic [WIDTH-1:0] secondQ;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    // first stage on the falling edge
    always_ff @(negedge clk or negedge rstN) begin
      if (!rstN) firstQ[i] <= 1'b0;
      else       firstQ[i] <= asyncIn[i];
    end
    // second stage on the rising edge
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) secondQ[i] <= 1'b0;
      else       secondQ[i] <= firstQ[i];
    end
  end

  assign syncOut = secondQ;

endmodule

// File: rtl/intarb_ctrl.sv
module intarb_ctrl
  import intarb_pkg::*;
(
  input  req_t          reqs,
  input  logic          instrBoundary,
  input  logic          delayHold,
  input  logic          segWrite,
  input  logic          prefixActive,
  output ctrl_strobes_t strobes
);

  logic boundaryOk;
  logic gateOpen;

  assign boundaryOk = instrBoundary & ~delayHold & ~segWrite & ~prefixActive;
  assign gateOpen   = boundaryOk & ~reqs.resetLevel;

  always_comb begin
    strobes            = '0;
    strobes.boundary   = instrBoundary;
    strobes.boundaryOk = boundaryOk;
    strobes.resetHold  = reqs.resetLevel;
    strobes.takeReset  = reqs.resetReq;
    if (gateOpen) begin
      if (reqs.nmiReq)        strobes.takeNmi  = 1'b1;
      else if (reqs.maskReq)  strobes.takeMask = 1'b1;
      else if (reqs.trapReq)  strobes.takeTrap = 1'b1;
    end
  end

endmodule

// File: rtl/intarb_dp.sv
module intarb_dp
  import intarb_pkg::*;
#(
  parameter int VEC_W    = 8,
  parameter int TRAP_VEC = 1,
  parameter int NMI_VEC  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             nmiSync,
  input  logic             intrSync,
  input  logic             resetSync,
  input  logic             trapFlag,
  input  logic             intEnable,
  input  ctrl_strobes_t    strobes,
  output req_t             reqs,
  output logic             takePulse,
  output logic [1:0]       entrySel,
  output logic             vecFixed,
  output logic [VEC_W-1:0] vecNum
);

  localparam logic [VEC_W-1:0] TrapVecL = VEC_W'(TRAP_VEC);
  localparam logic [VEC_W-1:0] NmiVecL  = VEC_W'(NMI_VEC);

  logic nmiPrev, resetPrev, nmiPending, trapArm;

  assign reqs.resetReq   = resetSync & ~resetPrev;
  assign reqs.resetLevel = resetSync;
  assign reqs.nmiReq     = nmiPending | (nmiSync & ~nmiPrev);
  assign reqs.maskReq    = intrSync & intEnable;
  assign reqs.trapReq    = trapArm;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nmiPrev    <= 1'b0;
      resetPrev  <= 1'b0;
      nmiPending <= 1'b0;
      trapArm    <= 1'b0;
    end else begin
      nmiPrev   <= nmiSync;
      resetPrev <= resetSync;
      if (strobes.resetHold || strobes.takeNmi) nmiPending <= 1'b0;
      else                                      nmiPending <= reqs.nmiReq;
      if (strobes.resetHold)
        trapArm <= 1'b0;
      else if (strobes.boundaryOk)
        trapArm <= trapFlag & ~(strobes.takeNmi | strobes.takeMask);
      else if (strobes.boundary)
        trapArm <= trapArm | trapFlag;
    end
  end

  logic             takeNext;
  entry_e           selNext;
  logic             fixedNext;
  logic [VEC_W-1:0] vecNext;

  always_comb begin
    takeNext  = 1'b0;
    selNext   = ENT_TRAP;
    fixedNext = 1'b0;
    vecNext   = '0;
    if (strobes.takeReset) begin
      takeNext = 1'b1;
      selNext  = ENT_RESET;
    end else if (strobes.takeNmi) begin
      takeNext  = 1'b1;
      selNext   = ENT_NMI;
      fixedNext = 1'b1;
      vecNext   = NmiVecL;
    end else if (strobes.takeMask) begin
      takeNext = 1'b1;
      selNext  = ENT_MASK;
    end else if (strobes.takeTrap) begin
      takeNext  = 1'b1;
      selNext   = ENT_TRAP;
      fixedNext = 1'b1;
      vecNext   = TrapVecL;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      takePulse <= 1'b0;
      entrySel  <= 2'd0;
      vecFixed  <= 1'b0;
      vecNum    <= '0;
    end else begin
      takePulse <= takeNext;
      entrySel  <= selNext;
      vecFixed  <= fixedNext;
      vecNum    <= vecNext;
    end
  end

endmodule

// File: rtl/intarb_top.sv
module intarb_top
  import intarb_pkg::*;
#(
  parameter int VEC_W    = 8,
  parameter int TRAP_VEC = 1,
  parameter int NMI_VEC  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             nmiPin,
  input  logic             intrPin,
  input  logic             resetPin,
  input  logic             trapFlag,
  input  logic             intEnable,
  input  logic             instrBoundary,
  input  logic             delayHold,
  input  logic             segWrite,
  input  logic             prefixActive,
  output logic             takePulse,
  output logic [1:0]       entrySel,
  output logic             vecFixed,
  output logic [VEC_W-1:0] vecNum
);

  localparam int PinCount = 3;

  logic [PinCount-1:0] pinSync;
  req_t                reqs;
  ctrl_strobes_t       strobes;

  intarb_sync #(.WIDTH(PinCount)) sync_i (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({resetPin, intrPin, nmiPin}),
    .syncOut (pinSync)
  );

  intarb_ctrl ctrl_i (
    .reqs          (reqs),
    .instrBoundary (instrBoundary),
    .delayHold     (delayHold),
    .segWrite      (segWrite),
    .prefixActive  (prefixActive),
    .strobes       (strobes)
  );

  intarb_dp #(.VEC_W(VEC_W), .TRAP_VEC(TRAP_VEC), .NMI_VEC(NMI_VEC)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .nmiSync   (pinSync[0]),
    .intrSync  (pinSync[1]),
    .resetSync (pinSync[2]),
    .trapFlag  (trapFlag),
    .intEnable (intEnable),
    .strobes   (strobes),
    .reqs      (reqs),
    .takePulse (takePulse),
    .entrySel  (entrySel),
    .vecFixed  (vecFixed),
    .vecNum    (vecNum)
  );

endmodule

// File: rtl/intarb_checker.sv
module intarb_checker #(
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             intEnable,
  input logic             instrBoundary,
  input logic             delayHold,
  input logic             segWrite,
  input logic             prefixActive,
  input logic             takePulse,
  input logic [1:0]       entrySel,
  input logic             vecFixed,
  input logic [VEC_W-1:0] vecNum
);

  // R10: idle outputs are zero
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !takePulse |-> (entrySel == 2'd0 && !vecFixed && vecNum == '0));

  // R3: non-maskable take carries vector 2
  a_r3_nmi_vector: assert property (@(posedge clk) disable iff (!rstN)
    (takePulse && entrySel == 2'd1) |-> (vecFixed && vecNum == VEC_W'(2)));

  // R6: trap take carries vector 1
  a_r6_trap_vector: assert property (@(posedge clk) disable iff (!rstN)
    (takePulse && entrySel == 2'd0) |-> (vecFixed && vecNum == VEC_W'(1)));

  // R5: maskable take needs enable and a boundary one cycle earlier
  a_r5_mask_enabled: assert property (@(posedge clk) disable iff (!rstN)
    (takePulse && entrySel == 2'd2) |-> ($past(intEnable) && $past(instrBoundary) && !vecFixed));

  // R7: non-reset takes only follow an unheld boundary
  a_r7_hold_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (takePulse && entrySel != 2'd3) |->
      $past(instrBoundary && !delayHold && !segWrite && !prefixActive));

  // R9: a reset take is a single pulse per edge
  a_r9_reset_single: assert property (@(posedge clk) disable iff (!rstN)
    (takePulse && entrySel == 2'd3) |=> !(takePulse && entrySel == 2'd3));

endmodule

bind intarb_top intarb_checker #(.VEC_W(VEC_W)) chk_i (
  .clk           (clk),
  .rstN          (rstN),
  .intEnable     (intEnable),
  .instrBoundary (instrBoundary),
  .delayHold     (delayHold),
  .segWrite      (segWrite),
  .prefixActive  (prefixActive),
  .takePulse     (takePulse),
  .entrySel      (entrySel),
  .vecFixed      (vecFixed),
  .vecNum        (vecNum)
);

// File: tb/intarb_tb.sv
module intarb_top_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic nmiPin = 0, intrPin = 0, resetPin = 0;
  logic trapFlag = 0, intEnable = 0, instrBoundary = 0;
  logic delayHold = 0, segWrite = 0, prefixActive = 0;
  logic       takePulse;
  logic [1:0] entrySel;
  logic       vecFixed;
  logic [7:0] vecNum;

  always #2 clk = ~clk;

  intarb_top dut_i (
    .clk(clk), .rstN(rstN), .nmiPin(nmiPin), .intrPin(intrPin), .resetPin(resetPin),
    .trapFlag(trapFlag), .intEnable(intEnable), .instrBoundary(instrBoundary),
    .delayHold(delayHold), .segWrite(segWrite), .prefixActive(prefixActive),
    .takePulse(takePulse), .entrySel(entrySel), .vecFixed(vecFixed), .vecNum(vecNum)
  );

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;
  string curTag = "R2";

  // model state
  bit lastNmi = 0, lastIntr = 0, lastRst = 0;
  bit mNmiPrev = 0, mRstPrev = 0, mPend = 0, mTrap = 0;
  bit       expTake = 0;
  int       expSel = 0;
  bit       expFixed = 0;
  int       expVec = 0;

  task automatic checkOut(string tag);
    string useTag;
    useTag = tag;
    if (expTake) begin
      case (expSel)
        0: useTag = "R6";
        1: useTag = "R3";
        2: useTag = "R5";
        default: useTag = "R9";
      endcase
    end
    testsRun++;
    if (takePulse !== expTake || int'(entrySel) != expSel ||
        vecFixed !== expFixed || int'(vecNum) != expVec) begin
      testsFailed++;
      $display("FAIL %s t=%0t actual take=%0b sel=%0d fixed=%0b vec=%0d expected take=%0b sel=%0d fixed=%0b vec=%0d",
               useTag, $time, takePulse, entrySel, vecFixed, vecNum,
               expTake, expSel, expFixed, expVec);
    end
  endtask

  // Compare the current outputs, then apply the inputs set by the caller and
  // advance the reference model by one cycle.
  task automatic tick();
    bit nS, iS, rS, nEdge, rEdge, ok, nReq;
    checkOut(curTag);
    nS = lastNmi; iS = lastIntr; rS = lastRst;   // R2: one cycle of sync delay
    lastNmi = nmiPin; lastIntr = intrPin; lastRst = resetPin;
    nEdge = nS && !mNmiPrev;
    rEdge = rS && !mRstPrev;
    ok = instrBoundary && !delayHold && !segWrite && !prefixActive;
    nReq = mPend || nEdge;
    expTake = 0; expSel = 0; expFixed = 0; expVec = 0;
    if (rS) begin
      if (rEdge) begin expTake = 1; expSel = 3; end
      mPend = 0; mTrap = 0;
    end else if (ok && nReq) begin
      expTake = 1; expSel = 1; expFixed = 1; expVec = 2;
      mPend = 0; mTrap = 0;
    end else if (ok && iS && intEnable) begin
      expTake = 1; expSel = 2;
      mPend = 0; mTrap = 0;
    end else begin
      if (ok && mTrap) begin expTake = 1; expSel = 0; expFixed = 1; expVec = 1; end
      mPend = nReq;
      if (ok) mTrap = trapFlag;
      else if (instrBoundary) mTrap = mTrap || trapFlag;
    end
    mNmiPrev = nS; mRstPrev = rS;
    @(posedge clk);
    #1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      instrBoundary = 0; tick();
    end
  endtask

  task automatic bnd();
    instrBoundary = 1; tick(); instrBoundary = 0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      testsFailed++;
      testsRun++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin : stim
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    testsRun++;
    if (takePulse !== 0 || entrySel !== 0 || vecFixed !== 0 || vecNum !== 0) begin
      testsFailed++;
      $display("FAIL R1 actual take=%0b sel=%0d fixed=%0b vec=%0d expected all 0",
               takePulse, entrySel, vecFixed, vecNum);
    end
    rstN = 1;
    curTag = "R1"; tick();

    // R3: short NMI pulse falls long before the boundary
    curTag = "R3";
    nmiPin = 1; tick(); nmiPin = 0;
    idle(5); bnd(); idle(2);

    // R4: pin held high across boundaries takes once
    curTag = "R4";
    nmiPin = 1; idle(3);
    for (int i = 0; i < 4; i++) begin bnd(); idle(1); end
    nmiPin = 0; idle(2); nmiPin = 1; idle(2); bnd(); idle(2); nmiPin = 0; idle(2);

    // R5: maskable only with enable, only when high at the boundary
    curTag = "R5";
    intrPin = 1; intEnable = 0; idle(2); bnd(); idle(1);
    intEnable = 1; bnd(); bnd(); idle(1);
    intrPin = 0; idle(1); intrPin = 1; tick(); intrPin = 0; idle(3); bnd(); idle(2);

    // R6: trap armed, then taken; discarded by an NMI take
    curTag = "R6";
    trapFlag = 1; bnd(); trapFlag = 0; idle(2); bnd(); idle(1); bnd(); idle(1);
    trapFlag = 1; bnd(); trapFlag = 0; nmiPin = 1; idle(3); nmiPin = 0;
    bnd(); idle(1); bnd(); idle(2);

    // R7: each hold in turn blocks a boundary, requests retained
    curTag = "R7";
    nmiPin = 1; tick(); nmiPin = 0; trapFlag = 1; idle(2);
    delayHold = 1; bnd(); delayHold = 0; idle(1);
    segWrite = 1; bnd(); segWrite = 0; idle(1);
    prefixActive = 1; bnd(); prefixActive = 0; trapFlag = 0; idle(1);
    bnd(); idle(1); bnd(); idle(2);

    // R8: all sources together, drained in priority order
    curTag = "R8";
    trapFlag = 1; bnd(); trapFlag = 0;
    nmiPin = 1; intrPin = 1; idle(2); nmiPin = 0;
    bnd(); bnd(); intrPin = 0; idle(2); bnd(); bnd(); idle(2);

    // R9: reset off-boundary, clears outstanding requests
    curTag = "R9";
    nmiPin = 1; tick(); nmiPin = 0; trapFlag = 1; bnd(); trapFlag = 0;
    resetPin = 1; idle(3); bnd(); idle(2); resetPin = 0; idle(2); bnd(); idle(2);

    // R8/R10: mixed pseudo-random traffic
    curTag = "R10";
    for (int i = 0; i < 4000; i++) begin
      nmiPin        = ($urandom_range(0, 15) == 0);
      intrPin       = ($urandom_range(0, 3) == 0);
      resetPin      = ($urandom_range(0, 63) == 0);
      trapFlag      = ($urandom_range(0, 3) == 0);
      intEnable     = ($urandom_range(0, 1) == 1);
      instrBoundary = ($urandom_range(0, 2) == 0);
      delayHold     = ($urandom_range(0, 7) == 0);
      segWrite      = ($urandom_range(0, 7) == 0);
      prefixActive  = ($urandom_range(0, 7) == 0);
      tick();
    end
    nmiPin = 0; intrPin = 0; resetPin = 0; trapFlag = 0; instrBoundary = 0;
    delayHold = 0; segWrite = 0; prefixActive = 0;
    idle(4);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule